// File: doc/BRIEF.md
# Dual-Processor Doorbell Interrupt Unit

This block lets two processors ring each other's doorbells. Each destination processor owns a small bank of pending flags. Another agent raises flags by writing ones to that bank's set register, and the owner drops them by writing ones to the clear register. A level interrupt line per bank stays high while any flag in the bank is pending, so the receiving processor can service every raised flag and then clear it.

The unit sits behind a 32-bit APB-style register port with a 4 KB window. A block of twelve fixed identification words sits at the top of that window. Any access that has no meaning is answered harmlessly and reported with a one-cycle error pulse. Such an access is an unmapped or misaligned offset, a read of a write-only register, or a write to a read-only one. The register port is a plain request/response bus with `pready` tied high, so there is never back-pressure. No streaming interface is present.

Top module: `xcpu_doorbell`

## Requirements
- R1: While `rst_n` is low at a clock edge, both flag banks are cleared. After that edge both interrupt lines are low and the status registers read 0.
- R2: A write to offset 0x04 (bank 0) or 0x14 (bank 1) ORs `pwdata[3:0]` into that bank's flags on the access-phase clock edge. `pwdata[31:4]` has no effect.
- R3: A write to offset 0x08 (bank 0) or 0x18 (bank 1) clears every flag of that bank whose bit in `pwdata[3:0]` is 1 and leaves the others unchanged. `pwdata[31:4]` has no effect.
- R4: `cpu_irq[0]` and `cpu_irq[1]` are high exactly when flag bank 0 or bank 1 respectively is nonzero, starting from the clock edge that commits the write.
- R5: A read of offset 0x00 (bank 0) or 0x10 (bank 1) returns that bank's flags in `prdata[3:0]` and zero in `prdata[31:4]`, with no error.
- R6: A read of a set or clear register returns 0 and raises `acc_err`. A write to a status register or to an identification word changes nothing and raises `acc_err`.
- R7: A read of the identification words at 0xFD0, 0xFD4, ... 0xFFC returns, in that address order, the bytes 0x04, 0x00, 0x00, 0x00, 0x56, 0xB8, 0x0B, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in `prdata[7:0]` and zero above, with no error.
- R8: An access to an offset that maps no register, or with `paddr[1:0]` not zero, reads 0, changes no flag and raises `acc_err`.
- R9: `acc_err` is high only during the access phase (`psel` and `penable` both high) of an erroneous access, and `pready` is always 1.
- R10: A write to one bank never changes the other bank's flags or interrupt line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and register clock |
| rst_n | input | 1 | Active-low synchronous reset |
| psel | input | 1 | Peripheral select |
| penable | input | 1 | Access-phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte offset in the 4 KB window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access phase |
| pready | output | 1 | Always 1, no wait states |
| acc_err | output | 1 | One-cycle pulse for an illegal or unmapped access |
| cpu_irq | output | 2 | Level interrupt per destination processor |

## Verification
The bus carries one access per cycle, so the functions that coincide are a flag-bank commit and what happens at the same edge around it. These are the other bank's interrupt, which must not move, and a status read placed in the very next access, which must already see the new value. The bench raises flags in one bank while the other bank holds a different pending pattern. It checks both interrupt lines and both status words right after that edge. It then issues a write immediately followed by a read of the same bank with no idle cycle between them, and judges the read against the expected flag value computed in the bench.

// File: rtl/dbell_pkg.sv
package dbell_pkg;

  // Register kinds inside the window
  typedef enum logic [2:0] {
    K_NONE = 3'd0,
    K_STAT = 3'd1,
    K_SET  = 3'd2,
    K_CLR  = 3'd3,
    K_ID   = 3'd4
  } reg_kind_e;

  localparam int ID_WORDS = 12;
  localparam int ID_IW    = 4;

  // Identification bytes, indexed by word position from the ID base upward
  function automatic logic [7:0] id_byte(input logic [ID_IW-1:0] idx);
    logic [7:0] v;
    case (idx)
      4'd0:    v = 8'h04;
      4'd4:    v = 8'h56;
      4'd5:    v = 8'hB8;
      4'd6:    v = 8'h0B;
      4'd8:    v = 8'h0D;
      4'd9:    v = 8'hF0;
      4'd10:   v = 8'h05;
      4'd11:   v = 8'hB1;
      default: v = 8'h00;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/dbell_decode.sv
module dbell_decode
  import dbell_pkg::*;
#(
  parameter int AW     = 12,
  parameter int NBANK  = 2,
  parameter int BANK_W = 1
) (
  input  logic [AW-1:0]     paddr,
  output reg_kind_e         kind,
  output logic [BANK_W-1:0] bank,
  output logic [ID_IW-1:0]  id_idx
);

  localparam int ID_BASE = (1 << AW) - ID_WORDS * 4;

  logic [AW-5:0] hi;
  logic [AW-1:0] id_off;

  assign hi     = paddr[AW-1:4];
  assign id_off = paddr - AW'(ID_BASE);

  always_comb begin
    kind   = K_NONE;
    bank   = '0;
    id_idx = '0;
    if (paddr[1:0] == 2'b00) begin
      if (int'(paddr) >= ID_BASE) begin
        kind   = K_ID;
        id_idx = id_off[ID_IW+1:2];
      end else if (int'(hi) < NBANK) begin
        bank = hi[BANK_W-1:0];
        case (paddr[3:2])
          2'd0:    kind = K_STAT;
          2'd1:    kind = K_SET;
          2'd2:    kind = K_CLR;
          default: kind = K_NONE;
        endcase
      end
    end
  end

endmodule

// File: rtl/dbell_flagbank.sv
module dbell_flagbank #(
  parameter int NFLAG = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_we,
  input  logic             clr_we,
  input  logic [NFLAG-1:0] wmask,
  output logic [NFLAG-1:0] flags,
  output logic             irq
);

  always_ff @(posedge clk) begin
    if (!rst_n)      flags <= '0;
    else if (set_we) flags <= flags | wmask;
    else if (clr_we) flags <= flags & ~wmask;
  end

  assign irq = |flags;

  // R2: every masked bit is pending after a set write
  p_set_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    set_we |=> ((flags & $past(wmask)) == $past(wmask)));

  // R3: every masked bit is gone after a clear write
  p_clr_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((flags & $past(wmask)) == '0));

  // R3: bits not named by a clear write survive it
  p_clr_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((flags & ~$past(wmask)) == ($past(flags) & ~$past(wmask))));

  // R10: without a strobe for this bank nothing moves
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_we && !clr_we) |=> $stable(flags));

endmodule

// File: rtl/dbell_idrom.sv
module dbell_idrom
  import dbell_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [ID_IW-1:0] idx,
  output logic [DW-1:0]    word
);

  assign word = DW'(id_byte(idx));

endmodule

// File: rtl/xcpu_doorbell.sv
module xcpu_doorbell
  import dbell_pkg::*;
#(
  parameter int AW    = 12,
  parameter int DW    = 32,
  parameter int NBANK = 2,
  parameter int NFLAG = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             psel,
  input  logic             penable,
  input  logic             pwrite,
  input  logic [AW-1:0]    paddr,
  input  logic [DW-1:0]    pwdata,
  output logic [DW-1:0]    prdata,
  output logic             pready,
  output logic             acc_err,
  output logic [NBANK-1:0] cpu_irq
);

  localparam int BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1;

  reg_kind_e          kind;
  logic [BANK_W-1:0]  bank;
  logic [ID_IW-1:0]   id_idx;
  logic [DW-1:0]      id_word;
  logic               acc;
  logic               bad;
  logic               wr_ok;
  logic [NFLAG-1:0]   flags [NBANK];
  logic [DW-1:0]      stat_word;
  logic               unused_hi;

  assign acc       = psel && penable;
  assign unused_hi = ^pwdata[DW-1:NFLAG];

  dbell_decode #(.AW(AW), .NBANK(NBANK), .BANK_W(BANK_W)) u_decode (
    .paddr  (paddr),
    .kind   (kind),
    .bank   (bank),
    .id_idx (id_idx)
  );

  dbell_idrom #(.DW(DW)) u_idrom (
    .idx  (id_idx),
    .word (id_word)
  );

  // Legality: direction must match the register kind
  always_comb begin
    case (kind)
      K_STAT, K_ID: bad = pwrite;
      K_SET, K_CLR: bad = !pwrite;
      default:      bad = 1'b1;
    endcase
  end

  assign acc_err = acc && bad;
  assign wr_ok   = acc && pwrite && !bad;
  assign pready  = 1'b1;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic sel;
    assign sel = (int'(bank) == b);

    dbell_flagbank #(.NFLAG(NFLAG)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_we (wr_ok && sel && (kind == K_SET)),
      .clr_we (wr_ok && sel && (kind == K_CLR)),
      .wmask  (pwdata[NFLAG-1:0]),
      .flags  (flags[b]),
      .irq    (cpu_irq[b])
    );

    // R4: an interrupt line only rises on the edge after a committed write
    p_irq_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cpu_irq[b]) |-> $past(acc && pwrite));

    // R1: reset leaves every line low
    p_reset_quiet_r1: assert property (@(posedge clk)
      !rst_n |=> !cpu_irq[b]);
  end

  always_comb begin
    stat_word = '0;
    for (int b = 0; b < NBANK; b++) begin
      if (int'(bank) == b) stat_word = DW'(flags[b]);
    end
  end

  always_comb begin
    prdata = '0;
    if (acc && !pwrite) begin
      case (kind)
        K_STAT:  prdata = stat_word;
        K_ID:    prdata = id_word;
        default: prdata = '0;
      endcase
    end
  end

  // R9: error only in an access phase
  p_err_phase_r9: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err |-> (psel && penable));

  // R6 / R8: an erroneous read returns zero
  p_bad_read_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_err && !pwrite) |-> (prdata == '0));

  // R8: an erroneous write leaves the interrupt lines steady
  p_bad_write_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_err && pwrite) |=> $stable(cpu_irq));

endmodule

// File: tb/xcpu_doorbell_bench.sv
module xcpu_doorbell_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0;
  logic        penable = 1'b0;
  logic        pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready;
  logic        acc_err;
  logic [1:0]  cpu_irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  xcpu_doorbell u_xcpu_doorbell (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .pready(pready), .acc_err(acc_err), .cpu_irq(cpu_irq)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, got, exp);
    end
  endtask

  // Access phase is sampled 1 ns after the negedge that opens it;
  // the commit edge lies before the negedge where the task returns.
  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d, output logic err);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1'b1;
    #1 err = acc_err;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic bus_rd(input logic [11:0] a, output logic [31:0] d, output logic err);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
    @(negedge clk);
    penable = 1'b1;
    #1 begin d = prdata; err = acc_err; end
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] d; logic e;
    chk("R1 irq after reset", {30'd0, cpu_irq}, 32'd0);
    chk("R9 pready", {31'd0, pready}, 32'd1);
    bus_rd(12'h000, d, e); chk("R1 stat0 after reset", d, 32'd0);
    bus_rd(12'h010, d, e); chk("R1 stat1 after reset", d, 32'd0);
  endtask

  task automatic t_set_clear;
    logic [31:0] d; logic e;
    bus_wr(12'h004, 32'hFFFF_FFF5, e);
    chk("R2 set err", {31'd0, e}, 32'd0);
    chk("R4 irq0 up", {30'd0, cpu_irq}, 32'd1);
    bus_rd(12'h000, d, e); chk("R2 upper bits masked", d, 32'h5);
    chk("R5 stat err", {31'd0, e}, 32'd0);
    bus_wr(12'h004, 32'h2, e);
    bus_rd(12'h000, d, e); chk("R2 OR semantics", d, 32'h7);
    bus_wr(12'h008, 32'hFFFF_FFF4, e);
    bus_rd(12'h000, d, e); chk("R3 partial clear", d, 32'h3);
    chk("R4 irq0 held", {30'd0, cpu_irq}, 32'd1);
    bus_wr(12'h008, 32'h3, e);
    chk("R4 irq0 down", {30'd0, cpu_irq}, 32'd0);
    bus_rd(12'h000, d, e); chk("R3 full clear", d, 32'h0);
  endtask

  task automatic t_independent;
    logic [31:0] d; logic e;
    bus_wr(12'h014, 32'h9, e);
    chk("R4 irq1 up only", {30'd0, cpu_irq}, 32'd2);
    bus_wr(12'h004, 32'h6, e);
    chk("R10 both lines", {30'd0, cpu_irq}, 32'd3);
    bus_rd(12'h010, d, e); chk("R10 bank1 kept", d, 32'h9);
    bus_rd(12'h000, d, e); chk("R5 bank0 read", d, 32'h6);
    bus_wr(12'h018, 32'hF, e);
    chk("R10 clear bank1 only", {30'd0, cpu_irq}, 32'd1);
    bus_rd(12'h000, d, e); chk("R10 bank0 kept", d, 32'h6);
  endtask

  task automatic t_back_to_back;
    logic e;
    // write then read with no idle cycle between
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = 12'h008; pwdata = 32'h2;
    @(negedge clk); penable = 1'b1;
    @(negedge clk);
    penable = 1'b0; pwrite = 1'b0; paddr = 12'h000;
    @(negedge clk); penable = 1'b1;
    #1 chk("R5 read right after write", prdata, 32'h4);
    e = acc_err;
    chk("R9 no err on legal read", {31'd0, e}, 32'd0);
    @(negedge clk); psel = 1'b0; penable = 1'b0;
    chk("R9 err idle", {31'd0, acc_err}, 32'd0);
  endtask

  task automatic t_direction;
    logic [31:0] d; logic e;
    bus_rd(12'h004, d, e); chk("R6 set reads zero", d, 32'd0);
    chk("R6 set read err", {31'd0, e}, 32'd1);
    bus_rd(12'h018, d, e); chk("R6 clr reads zero", d, 32'd0);
    chk("R6 clr read err", {31'd0, e}, 32'd1);
    bus_wr(12'h000, 32'hF, e); chk("R6 stat write err", {31'd0, e}, 32'd1);
    bus_rd(12'h000, d, e); chk("R6 stat write ignored", d, 32'h4);
    bus_wr(12'h010, 32'hF, e);
    bus_rd(12'h010, d, e); chk("R6 stat1 write ignored", d, 32'h0);
    bus_wr(12'hFE0, 32'hFF, e); chk("R6 id write err", {31'd0, e}, 32'd1);
    bus_rd(12'hFE0, d, e); chk("R6 id write ignored", d, 32'h56);
  endtask

  task automatic t_id;
    logic [31:0] d; logic e;
    logic [7:0] exp [12] = '{8'h04, 8'h00, 8'h00, 8'h00, 8'h56, 8'hB8,
                             8'h0B, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    for (int i = 0; i < 12; i++) begin
      bus_rd(12'hFD0 + 12'(i * 4), d, e);
      chk($sformatf("R7 id word %0d", i), d, {24'd0, exp[i]});
      chk("R7 id err", {31'd0, e}, 32'd0);
    end
  endtask

  task automatic t_unmapped;
    logic [31:0] d; logic e;
    bus_rd(12'h00C, d, e); chk("R8 hole read", d, 32'd0);
    chk("R8 hole err", {31'd0, e}, 32'd1);
    bus_rd(12'h800, d, e); chk("R8 far read", d, 32'd0);
    bus_wr(12'h024, 32'hF, e); chk("R8 bank2 write err", {31'd0, e}, 32'd1);
    bus_wr(12'h005, 32'hF, e); chk("R8 misaligned set err", {31'd0, e}, 32'd1);
    chk("R8 nothing raised", {30'd0, cpu_irq}, 32'd1);
    bus_rd(12'h000, d, e); chk("R8 bank0 untouched", d, 32'h4);
    bus_rd(12'h010, d, e); chk("R8 bank1 untouched", d, 32'h0);
    bus_rd(12'hFD2, d, e); chk("R8 misaligned id read", d, 32'd0);
  endtask

  task automatic t_reset_again;
    bus_wr(12'h014, 32'hA, e_dummy);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    chk("R1 reset clears live flags", {30'd0, cpu_irq}, 32'd0);
  endtask
  logic e_dummy;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_set_clear();
    t_independent();
    t_back_to_back();
    t_direction();
    t_id();
    t_unmapped();
    t_reset_again();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule